// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static memory. It runs a registered-input, registered-output pipeline and writes late: a write's data arrives on the shared data bus one clock after its address and controls. All controls and the address are taken only on the rising clock edge. A read registered on one edge loads the output register on the next edge, and that register drives the bus during the following cycle.

Each write is parked in an internal buffer until the next write's data comes in, and only then does it reach the array. Reads compare their address against the parked entry and merge in its enabled byte lanes, so a read always sees the newest data. The word is 36 or 18 bits wide and is split into 9-bit lanes that can be written on their own. A global write enable overrides the lane enables. The output enable acts without the clock. A sampled power-down input holds the block still.

Top module: `lw_sram`

## Requirements
- R1: While rst_n is low, the control pipeline, the output register and the bus drive are cleared, and the write buffer is emptied. A write still waiting in the buffer is dropped, and the array keeps its contents.
- R2: A read registered at rising edge E loads the output register at edge E+1, and the word is on dq during the cycle after E+1. Back-to-back reads return one word per cycle in the order they were issued.
- R3: The data of a write registered at edge E is sampled from dq at edge E+1.
- R4: Lane l covers dq bits 9l+8 down to 9l. Bit l of byte_we enables lane l, and only enabled lanes change. When gwe is high on a write, every lane is written whatever byte_we holds.
- R5: A read of the address held in the write buffer returns the buffer's enabled lanes merged over the array contents. This includes a read issued in the cycle right after the write.
- R6: A buffered write is committed to the array at the edge that captures the next write's data. It is read back correctly from the array after that edge.
- R7: A cycle with sel low makes no access, and wr_en has no effect in it. The output register and its drive state stay unchanged.
- R8: When oe goes low, dq is released at once with no clock edge. When oe goes high again, the held output word is driven at once.
- R9: When pwr_dn is high at an edge, any access offered at that edge is ignored. The output register, its drive state, the array and the write buffer all keep their values.
- R10: The output drive turns off at the edge that registers a write, which frees dq for that write's late data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sel | input | 1 | Synchronous select: high offers an access |
| wr_en | input | 1 | High makes the offered access a write, low a read |
| gwe | input | 1 | Global write enable: write all lanes |
| byte_we | input | WIDTH/9 | Per-lane write enables |
| addr | input | log2(DEPTH) | Word address |
| pwr_dn | input | 1 | Synchronous power-down |
| oe | input | 1 | Asynchronous output enable |
| dq | inout | WIDTH | Shared data bus: late write data in, read data out |

## Verification
The hardest case to reach is a read that hits the write buffer while the buffer holds only some lanes over older array data. A read of the same address must also land in the very cycle that the write's late data arrives on the bus. The bench reaches this by sweeping every lane-enable pattern on one address, with each write followed at once by a read-back. It also places a read in the data cycle of a write to the same address, and parks an uncommitted write across power-down and across reset. Each write in the sweep follows a read, so the checks also show that the bus turns around in time.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

   // width of one independently writable lane (8 data bits plus parity)
   localparam int LANE_W = 9;

   // kind of access held in the registered control stage
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   function automatic int lanes_for(input int width);
      return width / LANE_W;
   endfunction

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic              gwe,
   input  logic [LANES-1:0]  byte_we,
   input  logic [ADDR_W-1:0] addr,
   input  logic              pwr_dn,
   output logic              wr_take,
   output acc_e              acc_r,
   output logic [ADDR_W-1:0] addr_r,
   output logic [LANES-1:0]  mask_r
);

   localparam logic [LANES-1:0] ALL_LANES = {LANES{1'b1}};

   logic take;

   always_comb begin
      take    = sel && !pwr_dn;
      wr_take = take && wr_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_r  <= ACC_IDLE;
         addr_r <= '0;
         mask_r <= '0;
      end else if (!take) begin
         acc_r <= ACC_IDLE;
      end else if (wr_en) begin
         acc_r  <= ACC_WRITE;
         addr_r <= addr;
         mask_r <= gwe ? ALL_LANES : byte_we;
      end else begin
         acc_r  <= ACC_READ;
         addr_r <= addr;
      end
   end

   // R9
   pd_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (acc_r == ACC_IDLE));

   // R4
   gwe_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr_en && gwe && !pwr_dn) |=> (mask_r == ALL_LANES));

   // R7
   desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (acc_r == ACC_IDLE));

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
   import lw_sram_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   localparam int WIDTH = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANES-1:0]  wmask,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);

   // one storage bank per lane, so a lane write never touches its neighbours
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[l]) begin
            bank[waddr] <= wdata[l*LANE_W +: LANE_W];
         end
      end

      assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
   end

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   localparam int WIDTH = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LANES-1:0]  ld_mask,
   input  logic [WIDTH-1:0]  ld_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [WIDTH-1:0]  arr_q,
   output logic              cm_we,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [LANES-1:0]  cm_mask,
   output logic [WIDTH-1:0]  cm_data,
   output logic [WIDTH-1:0]  fwd_q
);

   logic              b_vld;
   logic [ADDR_W-1:0] b_addr;
   logic [LANES-1:0]  b_mask;
   logic [WIDTH-1:0]  b_data;
   logic              hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_vld  <= 1'b0;
         b_addr <= '0;
         b_mask <= '0;
         b_data <= '0;
      end else if (load) begin
         b_vld  <= 1'b1;
         b_addr <= ld_addr;
         b_mask <= ld_mask;
         b_data <= ld_data;
      end
   end

   // the old entry leaves for the array as the new one arrives
   always_comb begin
      cm_we   = load && b_vld;
      cm_addr = b_addr;
      cm_mask = b_mask;
      cm_data = b_data;
      hit     = b_vld && (b_addr == rd_addr);
   end

   for (genvar l = 0; l < LANES; l++) begin : g_merge
      assign fwd_q[l*LANE_W +: LANE_W] = (hit && b_mask[l]) ?
                                         b_data[l*LANE_W +: LANE_W] :
                                         arr_q[l*LANE_W +: LANE_W];
   end

   // R3
   late_data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (b_vld && b_data == $past(ld_data)));

   // R9
   buf_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(b_data) && $stable(b_addr) && $stable(b_mask)));

endmodule

// File: rtl/lw_sram.sv
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int WIDTH = 36,
   parameter int DEPTH = 256,
   localparam int LANES  = lanes_for(WIDTH),
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic              gwe,
   input  logic [LANES-1:0]  byte_we,
   input  logic [ADDR_W-1:0] addr,
   input  logic              pwr_dn,
   input  logic              oe,
   inout  wire  [WIDTH-1:0]  dq
);

   if (!(WIDTH == 36 || WIDTH == 18)) begin : g_bad_width
      $error("lw_sram: WIDTH must be 36 or 18");
   end
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("lw_sram: DEPTH must be a power of two, at least 2");
   end

   acc_e              acc_r;
   logic              wr_take;
   logic [ADDR_W-1:0] addr_r;
   logic [LANES-1:0]  mask_r;
   logic [WIDTH-1:0]  din;
   logic [WIDTH-1:0]  arr_q;
   logic [WIDTH-1:0]  fwd_q;
   logic              cm_we;
   logic [ADDR_W-1:0] cm_addr;
   logic [LANES-1:0]  cm_mask;
   logic [WIDTH-1:0]  cm_data;
   logic [WIDTH-1:0]  q_reg;
   logic              drive_r;
   logic              data_cyc;

   assign din      = dq;
   assign data_cyc = (acc_r == ACC_WRITE);

   lw_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .wr_en   (wr_en),
      .gwe     (gwe),
      .byte_we (byte_we),
      .addr    (addr),
      .pwr_dn  (pwr_dn),
      .wr_take (wr_take),
      .acc_r   (acc_r),
      .addr_r  (addr_r),
      .mask_r  (mask_r)
   );

   lw_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (data_cyc),
      .ld_addr (addr_r),
      .ld_mask (mask_r),
      .ld_data (din),
      .rd_addr (addr_r),
      .arr_q   (arr_q),
      .cm_we   (cm_we),
      .cm_addr (cm_addr),
      .cm_mask (cm_mask),
      .cm_data (cm_data),
      .fwd_q   (fwd_q)
   );

   lw_sram_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANES(LANES)) u_array (
      .clk   (clk),
      .we    (cm_we),
      .waddr (cm_addr),
      .wmask (cm_mask),
      .wdata (cm_data),
      .raddr (addr_r),
      .rdata (arr_q)
   );

   // output register and drive state; an incoming write wins the bus turnaround
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_reg   <= '0;
         drive_r <= 1'b0;
      end else begin
         if (acc_r == ACC_READ) begin
            q_reg <= fwd_q;
         end
         if (wr_take) begin
            drive_r <= 1'b0;
         end else if (acc_r == ACC_READ) begin
            drive_r <= 1'b1;
         end
      end
   end

   assign dq = (oe && drive_r) ? q_reg : {WIDTH{1'bz}};

   // R10
   bus_free_for_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_cyc |-> !drive_r);

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_r != ACC_READ) |=> $stable(q_reg));

   // R6
   commit_in_data_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cm_we |-> data_cyc);

   // R2
   read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_r == ACC_READ) && !wr_take) |=> drive_r);

endmodule

// File: tb/tb_lw_sram.sv
module tb_lw_sram;

   localparam int W  = 36;
   localparam int D  = 16;
   localparam int AW = 4;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0;
   logic          wr_en = 1'b0;
   logic          gwe = 1'b0;
   logic [NL-1:0] byte_we = '0;
   logic [AW-1:0] addr = '0;
   logic          pwr_dn = 1'b0;
   logic          oe = 1'b1;
   logic          tb_drv = 1'b0;
   logic [W-1:0]  tb_val = '0;
   wire  [W-1:0]  dq;

   int n_cmp = 0;
   int n_bad = 0;
   logic [W-1:0] mdl [D];

   assign dq = tb_drv ? tb_val : {W{1'bz}};

   always #10 clk = ~clk;

   lw_sram #(.WIDTH(W), .DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .gwe(gwe),
      .byte_we(byte_we), .addr(addr), .pwr_dn(pwr_dn), .oe(oe), .dq(dq)
   );

   function automatic logic [W-1:0] pat(input int a, input int s);
      logic [63:0] v;
      v = (64'(a) + 64'd1) * 64'h0000_0009_E377_9B97 + 64'(s) * 64'h0000_0007_3C1D_5A0F + 64'h1_0204_0811;
      return v[W-1:0];
   endfunction

   function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                          input logic [NL-1:0] m);
      logic [W-1:0] r;
      r = old;
      for (int l = 0; l < NL; l++) begin
         if (m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
      end
      return r;
   endfunction

   // one clock cycle: inputs set just after a falling edge, held over the rising edge
   task automatic step(input logic s, input logic w, input int a, input logic [NL-1:0] be,
                       input logic g, input logic pd, input logic drv, input logic [W-1:0] v);
      sel = s; wr_en = w; addr = AW'(a); byte_we = be; gwe = g; pwr_dn = pd;
      tb_drv = drv; tb_val = v;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [W-1:0] exp);
      n_cmp++;
      if (dq !== exp) begin
         n_bad++;
         $display("FAIL %s: dq actual %h expected %h", req, dq, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      step(0, 0, 0, '0, 0, 0, 0, '0);
      rst_n = 1'b1;

      // R3: pipelined full-word writes, each data word one cycle after its address
      step(1, 1, 0, '0, 1, 0, 0, '0);
      for (int a = 1; a < D; a++) begin
         step(1, 1, a, '0, 1, 0, 1, pat(a-1, 0));
         mdl[a-1] = pat(a-1, 0);
      end
      step(0, 0, 0, '0, 0, 0, 1, pat(D-1, 0));
      mdl[D-1] = pat(D-1, 0);

      // R2 R6: back-to-back reads, one word per cycle
      step(1, 0, 0, '0, 0, 0, 0, '0);
      for (int a = 1; a < D; a++) begin
         step(1, 0, a, '0, 0, 0, 0, '0);
         chk("R2/R6 pipelined read", mdl[a-1]);
      end
      step(0, 0, 0, '0, 0, 0, 0, '0);
      chk("R5 last write still buffered", mdl[D-1]);

      // R7: deselected cycles, with wr_en raised, leave the output as it was
      for (int k = 0; k < 3; k++) begin
         step(0, 1, 2, '1, 1, 0, 0, '0);
         chk("R7 deselect hold", mdl[D-1]);
      end

      // R4 R5 R10: every lane pattern on address 5, read straight back through the buffer
      for (int m = 0; m < 16; m++) begin
         step(1, 1, 5, NL'(m), 0, 0, 0, '0);
         step(0, 0, 0, '0, 0, 0, 1, pat(100 + m, 1));
         mdl[5] = merge(mdl[5], pat(100 + m, 1), NL'(m));
         step(1, 0, 5, '0, 0, 0, 0, '0);
         step(0, 0, 0, '0, 0, 0, 0, '0);
         chk("R4/R5/R10 lane write", mdl[5]);
      end

      // R4 R6: gwe overrides byte_we of zero; read after commit comes from the array
      step(1, 1, 5, '0, 1, 0, 0, '0);
      step(0, 0, 0, '0, 0, 0, 1, pat(200, 2));
      mdl[5] = pat(200, 2);
      step(1, 1, 6, '1, 0, 0, 0, '0);
      step(0, 0, 0, '0, 0, 0, 1, pat(201, 2));
      mdl[6] = pat(201, 2);
      step(1, 0, 5, '0, 0, 0, 0, '0);
      step(0, 0, 0, '0, 0, 0, 0, '0);
      chk("R4/R6 global write committed", mdl[5]);

      // R5: read of address 7 registered in the data cycle of its own write
      step(1, 1, 7, '0, 1, 0, 0, '0);
      step(1, 0, 7, '0, 0, 0, 1, pat(300, 3));
      mdl[7] = pat(300, 3);
      step(0, 0, 0, '0, 0, 0, 0, '0);
      chk("R5 read in write data cycle", mdl[7]);

      // R9: accesses offered during power-down are ignored; buffer survives
      step(1, 1, 7, '1, 1, 1, 0, '0);
      chk("R9 output kept in power-down", mdl[7]);
      step(1, 0, 8, '0, 0, 1, 0, '0);
      step(0, 0, 0, '0, 0, 1, 0, '0);
      chk("R9 read ignored in power-down", mdl[7]);
      step(1, 0, 7, '0, 0, 0, 0, '0);
      step(1, 0, 8, '0, 0, 0, 0, '0);
      chk("R9 buffered write kept", mdl[7]);
      step(0, 0, 0, '0, 0, 0, 0, '0);
      chk("R9 array kept", mdl[8]);

      // R8: output enable acts between clock edges
      oe = 1'b0;
      tb_drv = 1'b1;
      tb_val = ~mdl[8];
      #2;
      chk("R8 oe low releases bus", ~mdl[8]);
      tb_drv = 1'b0;
      oe = 1'b1;
      #2;
      chk("R8 oe high drives held word", mdl[8]);
      @(negedge clk);

      // R1: reset drops the uncommitted write to address 9
      step(1, 1, 9, '0, 1, 0, 0, '0);
      step(0, 0, 0, '0, 0, 0, 1, pat(400, 4));
      rst_n = 1'b0;
      step(0, 0, 0, '0, 0, 0, 0, '0);
      rst_n = 1'b1;
      step(1, 0, 9, '0, 0, 0, 0, '0);
      step(0, 0, 0, '0, 0, 0, 0, '0);
      chk("R1 pending write dropped by reset", mdl[9]);
      step(1, 0, 6, '0, 0, 0, 0, '0);
      step(0, 0, 0, '0, 0, 0, 0, '0);
      chk("R1 array kept over reset", mdl[6]);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule